// File: doc/BRIEF.md
# Compare-Match Status Flags with Read-Armed Clear

This block keeps two compare-match status flags, named E and F, inside one 8-bit status byte. Each flag latches high when a free-running timer counter becomes equal to its own general register while that register is set to compare mode. Only the first cycle of equality counts, so a counter that stops on the matching value raises the flag once and does not raise it again.

Software clears a flag in two steps. First it reads the status byte and sees the flag at 1, which arms that flag. Then it writes 0 to the flag's bit. A write of 0 to a flag that is not armed does nothing. A new compare match on a flag after it was armed removes the arming, so software must read the flag again before a clear can take effect. Each flag also drives a level interrupt request that follows its state.

Top module: `cmf_status`

## Requirements
- R1: After synchronous reset both flags are 0, both interrupt requests are low, and the status byte reads 8'hC0.
- R2: Status bits 7 and 6 always read 1 and bits 5 to 2 always read 0. Writes to those bits have no effect.
- R3: Flag E (status bit 0) is 1 in the cycle after the counter first equals register E while compare mode E is high. Flag F (bit 1) behaves the same way with register F. With compare mode low, equality sets nothing.
- R4: Writing 0 to a flag that has not been read as 1 since its last arming event leaves the flag at 1.
- R5: A read that returns a flag as 1, followed by a write with that flag's bit at 0, clears the flag. The cleared value reads back in the cycle after the write.
- R6: Writing 1 to a flag bit never changes the flag, and software cannot set a flag.
- R7: A compare match on a flag between its arming read and the clearing write cancels the arming. The write then leaves the flag at 1, and a fresh read as 1 is needed before a write of 0 clears it.
- R8: When a compare-match event and a clearing write for the same flag fall in the same cycle, the flag stays 1.
- R9: Equality that continues over several cycles counts as a single event. After the flag is cleared while the counter stays equal, the flag stays 0.
- R10: irq_e and irq_f are high exactly while flag E and flag F are 1.
- R11: The flags are armed and cleared independently. Reading E as 1 while F is 0 does not arm F, and clearing E leaves F unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Address decode selects the status byte |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read strobe; arms any flag that reads as 1 |
| bus_wdata | input | 8 | Write data; a 0 in bit 0 or bit 1 requests a clear of that flag |
| bus_rdata | output | 8 | Status byte: {2'b11, 4'b0000, flag F, flag E} |
| count | input | CNT_W | Free-running timer counter value |
| cmp_e | input | CNT_W | General register E value |
| cmp_f | input | CNT_W | General register F value |
| cmp_mode_e | input | 1 | Register E works as a compare register |
| cmp_mode_f | input | 1 | Register F works as a compare register |
| irq_e | output | 1 | Level interrupt request for flag E |
| irq_f | output | 1 | Level interrupt request for flag F |

## Verification
Each flag has two hidden state bits: its previous-equality bit and its arming latch. A wrong arming latch shows up on the first write of 0 after the bad state appears. That write either clears a flag that should stay set or fails to clear one that should clear, and the error is visible on the status byte and on the interrupt request one cycle later. A stale previous-equality bit shows up as a flag that sets again or fails to set one cycle after a held or repeated equality, so the scenarios hold the counter on the match value and place events exactly between the read and the write.

// File: rtl/cmf_pkg.sv
package cmf_pkg;

    localparam int STATUS_W   = 8;
    localparam int NUM_FLAGS  = 2;
    localparam int FLAG_E_IDX = 0;
    localparam int FLAG_F_IDX = 1;

    localparam logic [STATUS_W-1:0] FIXED_ONES = 8'hC0;

    typedef struct packed {
        logic                sel;
        logic                rd;
        logic                wr;
        logic [STATUS_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic event_hit;
        logic read_hit;
        logic clr_req;
    } flag_ctl_t;

    function automatic logic [STATUS_W-1:0] pack_status(input logic [NUM_FLAGS-1:0] f);
        logic [STATUS_W-1:0] v;
        v = FIXED_ONES;
        v[NUM_FLAGS-1:0] = f;
        return v;
    endfunction

endpackage

// File: rtl/cmf_match_detect.sv
module cmf_match_detect #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  logic             mode,
    output logic             match_evt
);

    logic eq_now;
    logic eq_prev;

    assign eq_now    = mode && (count == cmp);
    assign match_evt = eq_now && !eq_prev;

    always_ff @(posedge clk) begin
        if (rst) eq_prev <= 1'b0;
        else     eq_prev <= eq_now;
    end

    // R9: one event per run of equality
    p_single_event_r9: assert property (@(posedge clk) disable iff (rst)
        match_evt |=> !match_evt);

endmodule

// File: rtl/cmf_flag_cell.sv
module cmf_flag_cell
    import cmf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_ctl_t ctl,
    output logic      flag
);

    typedef enum logic {ARM_IDLE = 1'b0, ARM_READY = 1'b1} arm_state_t;

    arm_state_t arm_q;
    arm_state_t arm_d;
    logic       flag_d;
    logic       do_clear;

    assign do_clear = ctl.clr_req && (arm_q == ARM_READY);

    always_comb begin
        flag_d = flag;
        if (ctl.event_hit)  flag_d = 1'b1;
        else if (do_clear)  flag_d = 1'b0;

        arm_d = arm_q;
        if (ctl.event_hit)                arm_d = ARM_IDLE;
        else if (do_clear)                arm_d = ARM_IDLE;
        else if (ctl.read_hit && flag)    arm_d = ARM_READY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            arm_q <= ARM_IDLE;
        end else begin
            flag  <= flag_d;
            arm_q <= arm_d;
        end
    end

    p_event_sets_r3: assert property (@(posedge clk) disable iff (rst)
        ctl.event_hit |=> flag);

    p_unarmed_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (flag && arm_q == ARM_IDLE) |=> flag);

    p_armed_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl.clr_req && arm_q == ARM_READY && !ctl.event_hit) |=> !flag);

    p_no_sw_set_r6: assert property (@(posedge clk) disable iff (rst)
        (!flag && !ctl.event_hit) |=> !flag);

    p_event_disarms_r7: assert property (@(posedge clk) disable iff (rst)
        ctl.event_hit |=> (arm_q == ARM_IDLE));

    p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl.event_hit && ctl.clr_req) |=> flag);

endmodule

// File: rtl/cmf_status.sv
module cmf_status
    import cmf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [STATUS_W-1:0] bus_wdata,
    output logic [STATUS_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]    count,
    input  logic [CNT_W-1:0]    cmp_e,
    input  logic [CNT_W-1:0]    cmp_f,
    input  logic                cmp_mode_e,
    input  logic                cmp_mode_f,
    output logic                irq_e,
    output logic                irq_f
);

    bus_req_t             req;
    logic [CNT_W-1:0]     cmp_vals [NUM_FLAGS];
    logic [NUM_FLAGS-1:0] cmp_modes;
    logic [NUM_FLAGS-1:0] events;
    logic [NUM_FLAGS-1:0] flags;
    logic                 unused_wbits;

    assign req.sel   = bus_sel;
    assign req.rd    = bus_rd;
    assign req.wr    = bus_wr;
    assign req.wdata = bus_wdata;

    assign cmp_vals[FLAG_E_IDX]  = cmp_e;
    assign cmp_vals[FLAG_F_IDX]  = cmp_f;
    assign cmp_modes[FLAG_E_IDX] = cmp_mode_e;
    assign cmp_modes[FLAG_F_IDX] = cmp_mode_f;

    assign unused_wbits = ^req.wdata[STATUS_W-1:NUM_FLAGS];

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        flag_ctl_t ctl;

        cmf_match_detect #(.CNT_W(CNT_W)) u_det (
            .clk       (clk),
            .rst       (rst),
            .count     (count),
            .cmp       (cmp_vals[i]),
            .mode      (cmp_modes[i]),
            .match_evt (events[i])
        );

        assign ctl.event_hit = events[i];
        assign ctl.read_hit  = req.sel && req.rd;
        assign ctl.clr_req   = req.sel && req.wr && !req.wdata[i];

        cmf_flag_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl),
            .flag (flags[i])
        );
    end

    assign bus_rdata = pack_status(flags);
    assign irq_e     = flags[FLAG_E_IDX];
    assign irq_f     = flags[FLAG_F_IDX];

endmodule

// File: tb/cmf_status_tb.sv
module cmf_status_tb;

    localparam int CW = 16;
    localparam logic [CW-1:0] VE = 16'h0040;
    localparam logic [CW-1:0] VF = 16'h0080;
    localparam logic [CW-1:0] IDLE = 16'h0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic [CW-1:0] count = IDLE;
    logic [CW-1:0] cmp_e = VE, cmp_f = VF;
    logic          cmp_mode_e = 1'b1, cmp_mode_f = 1'b1;
    logic          irq_e, irq_f;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cmf_status #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .cmp_e(cmp_e), .cmp_f(cmp_f),
        .cmp_mode_e(cmp_mode_e), .cmp_mode_f(cmp_mode_f),
        .irq_e(irq_e), .irq_f(irq_f)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic bus_read(output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
        #1;
    endtask

    task automatic bus_write(input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
        #1;
    endtask

    task automatic pulse_count(input logic [CW-1:0] v);
        @(negedge clk);
        count = v;
        @(negedge clk);
        count = IDLE;
        #1;
    endtask

    task automatic clear_all();
        logic [7:0] d;
        bus_read(d);
        bus_write(8'h00);
    endtask

    task automatic t_reset();
        check("R1 status after reset", bus_rdata, 8'hC0);
        check("R1 irq after reset", {6'b0, irq_f, irq_e}, 8'h00);
    endtask

    task automatic t_mode_off();
        cmp_mode_e = 1'b0;
        pulse_count(VE);
        check("R3 no set with compare mode off", bus_rdata, 8'hC0);
        cmp_mode_e = 1'b1;
    endtask

    task automatic t_set_and_clear();
        logic [7:0] d;
        pulse_count(VE);
        check("R3 flag E set", bus_rdata, 8'hC1);
        check("R10 irq_e high", {7'b0, irq_e}, 8'h01);
        bus_write(8'h00);
        check("R4 unarmed write 0 keeps flag", bus_rdata, 8'hC1);
        bus_write(8'hFF);
        check("R6 write 1 keeps flag, R2 fixed bits", bus_rdata, 8'hC1);
        bus_read(d);
        check("R5 read sees flag E", d, 8'hC1);
        bus_write(8'h3E);
        check("R5 armed write 0 clears E, R2 fixed bits", bus_rdata, 8'hC0);
        check("R10 irq_e low after clear", {7'b0, irq_e}, 8'h00);
        bus_write(8'hFF);
        check("R6 write 1 cannot set flags", bus_rdata, 8'hC0);
    endtask

    task automatic t_set_f();
        pulse_count(VF);
        check("R3 flag F set on bit 1", bus_rdata, 8'hC2);
        check("R10 irq_f high", {7'b0, irq_f}, 8'h01);
        clear_all();
        check("R5 flag F cleared", bus_rdata, 8'hC0);
    endtask

    task automatic t_cancel();
        logic [7:0] d;
        pulse_count(VE);
        bus_read(d);
        pulse_count(VE);
        bus_write(8'h00);
        check("R7 match after read blocks clear", bus_rdata, 8'hC1);
        bus_read(d);
        bus_write(8'h00);
        check("R7 fresh read allows clear", bus_rdata, 8'hC0);
    endtask

    task automatic t_same_cycle();
        logic [7:0] d;
        pulse_count(VE);
        bus_read(d);
        @(negedge clk);
        count = VE;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h00;
        @(negedge clk);
        count = IDLE;
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
        check("R8 set wins over clear", bus_rdata, 8'hC1);
        bus_write(8'h00);
        check("R8 arming dropped after collision", bus_rdata, 8'hC1);
        clear_all();
        check("R8 later clear works", bus_rdata, 8'hC0);
    endtask

    task automatic t_held_equal();
        logic [7:0] d;
        @(negedge clk);
        count = VE;
        tick();
        check("R9 held equality sets flag", bus_rdata, 8'hC1);
        bus_read(d);
        bus_write(8'h00);
        check("R9 clear while equal", bus_rdata, 8'hC0);
        tick(); tick(); tick();
        check("R9 held equality no new set", bus_rdata, 8'hC0);
        @(negedge clk);
        count = IDLE;
        #1;
    endtask

    task automatic t_independent();
        logic [7:0] d;
        pulse_count(VE);
        bus_read(d);
        check("R11 read shows only E", d, 8'hC1);
        pulse_count(VF);
        check("R11 both flags set", bus_rdata, 8'hC3);
        bus_write(8'h00);
        check("R11 only armed E cleared", bus_rdata, 8'hC2);
        bus_read(d);
        bus_write(8'h01);
        check("R11 bit1=0 clears F only", bus_rdata, 8'hC0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_mode_off();
        t_set_and_clear();
        t_set_f();
        t_cancel();
        t_same_cycle();
        t_held_equal();
        t_independent();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule